// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block forms the 16-bit address used by an 8-bit microcontroller's operand addressing modes. Given a mode code, an immediate field, the HL, DE and BC register-pair values, the register-bank select, a register number and the current program counter, it produces the data-memory address of the operand. For the call and branch modes it produces the branch target instead: the short-field call target, the table-call pointer address and the relative-branch target. Alongside the address it raises a flag when a data access lands in the special-function-register page.

The address is computed combinationally. A parameter chooses whether it is presented directly or through one output register stage. The register stage is the default, and it gives one cycle of latency from inputs to outputs. Memory access, register-file storage and instruction decode are done elsewhere. The pipeline feeds this block with register values that are already read and with a mode that is already decoded.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (direct) gives an address equal to the full 16-bit immediate.
- R2: Mode code 1 (short direct) takes offset imm[7:0]. An offset of 20h..FFh maps to FE20h..FEFFh, and an offset of 00h..1Fh maps to FF00h..FF1Fh. Bits 15..9 of the address are always 1 and bit 8 is set exactly when the offset is below 20h.
- R3: Mode code 2 (special-function register) gives FF00h + imm[7:0].
- R4: Mode code 3 gives the DE value as the address, and mode code 4 gives the HL value.
- R5: Mode code 5 (based) gives HL + zero-extended imm[7:0], wrapping modulo 2^16.
- R6: Mode code 6 gives HL + B and mode code 7 gives HL + C, with B = bc[15:8], C = bc[7:0], zero-extended and wrapping modulo 2^16.
- R7: Mode code 8 (register operand) gives FEE0h + 8*(3 - bank) + regnum, so bank 0 spans FEF8h..FEFFh and bank 3 spans FEE0h..FEE7h.
- R8: Mode code 9 (short-field call) gives {00001b, imm[10:0]}, which always lies in 0800h..0FFFh.
- R9: Mode code 10 (table call) gives the pointer address 0040h + 2*imm[4:0]. This is always even and lies in 0040h..007Eh.
- R10: Mode code 11 (relative branch) gives PC + BR_LEN + sign-extended imm[7:0], wrapping modulo 2^16. BR_LEN defaults to 2.
- R11: The region flag is 1 exactly when the mode is a data mode (codes 0..8) and the address lies in FF00h..FFFFh. It is always 0 for modes 9..11.
- R12: Unused mode codes 12..15 give address 0000h and a region flag of 0.
- R13: With OUT_REG=1, the outputs show the inputs' result one clock later, and reset drives both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Addressing mode code |
| imm_i | input | 16 | Immediate / offset / displacement field |
| hl_i | input | 16 | HL register-pair value |
| de_i | input | 16 | DE register-pair value |
| bc_i | input | 16 | BC register-pair value (B high, C low) |
| bank_i | input | 2 | Active register bank |
| regnum_i | input | 3 | Register number within the bank |
| pc_i | input | 16 | Current program counter |
| ea_o | output | 16 | Effective address or branch target |
| sfr_o | output | 1 | Data access falls in FF00h..FFFFh |

## Verification
Short-direct offsets 1Fh, 20h and FFh sit on both sides of the window split. They separate a wrong threshold from a wrong window base, and they show whether the region flag follows the lower window. Based and indexed sums with HL near FFFFh expose a missing wrap, and relative branches with displacements 7Fh and 80h from PC 0000h and FFFFh separate sign extension from zero extension. Register operands in banks 0 and 3 show whether the bank order is reversed. Random mixes over all sixteen mode codes check the unused codes and make sure no mode leaks into another.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    AM_DIRECT = 4'd0,
    AM_SHORT  = 4'd1,
    AM_SFR    = 4'd2,
    AM_IND_DE = 4'd3,
    AM_IND_HL = 4'd4,
    AM_BASED  = 4'd5,
    AM_IDX_B  = 4'd6,
    AM_IDX_C  = 4'd7,
    AM_REG    = 4'd8,
    AM_CALL11 = 4'd9,
    AM_TABLE  = 4'd10,
    AM_REL    = 4'd11
  } am_mode_e;

  // Short-direct window: bit 8 picks the upper page for low offsets.
  function automatic logic [ADDR_W-1:0] am_short(input logic [BYTE_W-1:0] off);
    logic low_page;
    low_page = (off < 8'h20);
    return {7'h7F, low_page, off};
  endfunction

  function automatic logic [ADDR_W-1:0] am_sfr(input logic [BYTE_W-1:0] off);
    return {8'hFF, off};
  endfunction

  function automatic logic [ADDR_W-1:0] am_add8(input logic [ADDR_W-1:0] base,
                                                input logic [BYTE_W-1:0] val);
    return base + {{(ADDR_W-BYTE_W){1'b0}}, val};
  endfunction

  // Bank n sits at FEE0h + 8*(3-n); 3-n equals the bitwise inverse of n.
  function automatic logic [ADDR_W-1:0] am_regslot(input logic [1:0] bank,
                                                   input logic [2:0] rn);
    return {11'b1111_1110_111, ~bank, rn};
  endfunction

  function automatic logic [ADDR_W-1:0] am_call11(input logic [10:0] f11);
    return {5'b00001, f11};
  endfunction

  function automatic logic [ADDR_W-1:0] am_table(input logic [4:0] ta);
    return {9'd0, 1'b1, ta, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] am_rel(input logic [ADDR_W-1:0] pc,
                                               input logic [BYTE_W-1:0] disp,
                                               input logic [ADDR_W-1:0] len);
    return pc + len + {{(ADDR_W-BYTE_W){disp[BYTE_W-1]}}, disp};
  endfunction

endpackage

// File: rtl/opaddr_data.sv
module opaddr_data
  import opaddr_pkg::*;
(
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] de_i,
  input  logic [ADDR_W-1:0] bc_i,
  input  logic [1:0]        bank_i,
  input  logic [2:0]        regnum_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              hit_o
);
  always_comb begin
    ea_o  = '0;
    hit_o = 1'b1;
    case (am_mode_e'(mode_i))
      AM_DIRECT: ea_o = imm_i;
      AM_SHORT:  ea_o = am_short(imm_i[7:0]);
      AM_SFR:    ea_o = am_sfr(imm_i[7:0]);
      AM_IND_DE: ea_o = de_i;
      AM_IND_HL: ea_o = hl_i;
      AM_BASED:  ea_o = am_add8(hl_i, imm_i[7:0]);
      AM_IDX_B:  ea_o = am_add8(hl_i, bc_i[15:8]);
      AM_IDX_C:  ea_o = am_add8(hl_i, bc_i[7:0]);
      AM_REG:    ea_o = am_regslot(bank_i, regnum_i);
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/opaddr_branch.sv
module opaddr_branch
  import opaddr_pkg::*;
#(
  parameter int unsigned BR_LEN = 2
) (
  input  logic [3:0]        mode_i,
  input  logic [10:0]       field_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LEN_C = ADDR_W'(BR_LEN);

  always_comb begin
    tgt_o = '0;
    hit_o = 1'b1;
    case (am_mode_e'(mode_i))
      AM_CALL11: tgt_o = am_call11(field_i);
      AM_TABLE:  tgt_o = am_table(field_i[4:0]);
      AM_REL:    tgt_o = am_rel(pc_i, field_i[7:0], LEN_C);
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/opaddr_stage.sv
module opaddr_stage
  import opaddr_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              flag_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              flag_o
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ea_o   <= '0;
          flag_o <= 1'b0;
        end else begin
          ea_o   <= ea_i;
          flag_o <= flag_i;
        end
      end
    end else begin : g_comb
      assign ea_o   = ea_i;
      assign flag_o = flag_i;
    end
  endgenerate
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int unsigned BR_LEN  = 2,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  mode_i,
  input  logic [15:0] imm_i,
  input  logic [15:0] hl_i,
  input  logic [15:0] de_i,
  input  logic [15:0] bc_i,
  input  logic [1:0]  bank_i,
  input  logic [2:0]  regnum_i,
  input  logic [15:0] pc_i,
  output logic [15:0] ea_o,
  output logic        sfr_o
);
  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] data_ea, br_ea, ea_nx;
  logic              data_hit, br_hit, sfr_nx;

  opaddr_data u_data (
    .mode_i   (mode_i),
    .imm_i    (imm_i),
    .hl_i     (hl_i),
    .de_i     (de_i),
    .bc_i     (bc_i),
    .bank_i   (bank_i),
    .regnum_i (regnum_i),
    .ea_o     (data_ea),
    .hit_o    (data_hit)
  );

  opaddr_branch #(.BR_LEN(BR_LEN)) u_branch (
    .mode_i  (mode_i),
    .field_i (imm_i[10:0]),
    .pc_i    (pc_i),
    .tgt_o   (br_ea),
    .hit_o   (br_hit)
  );

  always_comb begin
    if (data_hit)    ea_nx = data_ea;
    else if (br_hit) ea_nx = br_ea;
    else             ea_nx = '0;
  end

  assign sfr_nx = data_hit && (data_ea[15:8] == 8'hFF);

  opaddr_stage #(.OUT_REG(OUT_REG)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .ea_i   (ea_nx),
    .flag_i (sfr_nx),
    .ea_o   (ea_o),
    .flag_o (sfr_o)
  );
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode_i,
  input logic [15:0] imm_i,
  input logic [1:0]  bank_i,
  input logic [15:0] ea_nx,
  input logic        sfr_nx,
  input logic [15:0] ea_o,
  input logic        sfr_o
);
  // R2: both windows, and the flag follows the low-offset window
  p_short_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd1) |-> (ea_nx[15:9] == 7'h7F) &&
                         (ea_nx[8] == (imm_i[7:0] < 8'h20)) &&
                         (sfr_nx == (imm_i[7:0] < 8'h20)));

  p_sfr_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd2) |-> (ea_nx[15:8] == 8'hFF) && (ea_nx[7:0] == imm_i[7:0]) && sfr_nx);

  p_reg_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd8) |-> (ea_nx >= 16'hFEE0) && (ea_nx <= 16'hFEFF) &&
                         (ea_nx[4:3] == 2'(3 - bank_i)));

  p_call_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd9) |-> (ea_nx >= 16'h0800) && (ea_nx <= 16'h0FFF));

  p_table_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd10) |-> (ea_nx >= 16'h0040) && (ea_nx <= 16'h007E) && !ea_nx[0]);

  p_branch_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 4'd9) |-> !sfr_nx);

  p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 4'd12) |-> (ea_nx == 16'h0000));

  generate
    if (OUT_REG) begin : g_lat
      p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ea_o == $past(ea_nx)) && (sfr_o == $past(sfr_nx)));
    end else begin : g_pass
      p_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_o == ea_nx) && (sfr_o == sfr_nx));
    end
  endgenerate
endmodule

bind opaddr_gen opaddr_gen_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_i (mode_i),
  .imm_i  (imm_i),
  .bank_i (bank_i),
  .ea_nx  (ea_nx),
  .sfr_nx (sfr_nx),
  .ea_o   (ea_o),
  .sfr_o  (sfr_o)
);

// File: tb/tb_opaddr_gen.sv
`timescale 1ns/1ps
module tb_opaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode;
  logic [15:0] imm, hl, de, bc, pc;
  logic [1:0]  bank;
  logic [2:0]  rn;
  logic [15:0] ea;
  logic        sfr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  opaddr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .imm_i(imm), .hl_i(hl),
    .de_i(de), .bc_i(bc), .bank_i(bank), .regnum_i(rn), .pc_i(pc),
    .ea_o(ea), .sfr_o(sfr)
  );

  // Reference model written from the requirements.
  function automatic logic [15:0] ref_ea(input logic [3:0] m);
    int unsigned t;
    case (m)
      4'd0:  return imm;                                             // R1
      4'd1:  return (imm[7:0] < 8'h20) ? 16'hFF00 + 16'(imm[7:0])
                                       : 16'hFE00 + 16'(imm[7:0]);   // R2
      4'd2:  return 16'hFF00 + 16'(imm[7:0]);                        // R3
      4'd3:  return de;                                              // R4
      4'd4:  return hl;
      4'd5:  begin t = hl + imm[7:0]; return t[15:0]; end            // R5
      4'd6:  begin t = hl + bc[15:8]; return t[15:0]; end            // R6
      4'd7:  begin t = hl + bc[7:0];  return t[15:0]; end
      4'd8:  return 16'hFEF8 - 16'(8 * bank) + 16'(rn);              // R7
      4'd9:  return 16'h0800 + 16'(imm[10:0]);                       // R8
      4'd10: return 16'h0040 + 16'(2 * imm[4:0]);                    // R9
      4'd11: begin
               t = pc + 2 + ((imm[7] ? 32'hFFFF_FF00 : 32'h0) | 32'(imm[7:0]));
               return t[15:0];                                        // R10
             end
      default: return 16'h0000;                                      // R12
    endcase
  endfunction

  function automatic logic ref_sfr(input logic [3:0] m, input logic [15:0] a);
    return (m <= 4'd8) && (a >= 16'hFF00);                           // R11
  endfunction

  task automatic check(input string req, input logic [15:0] got_a, input logic got_f,
                       input logic [15:0] exp_a, input logic exp_f);
    checks++;
    if (got_a !== exp_a || got_f !== exp_f) begin
      fails++;
      $display("FAIL %s: ea=%h sfr=%b expected ea=%h sfr=%b", req, got_a, got_f, exp_a, exp_f);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the capturing rising edge (R13).
  task automatic run(input string req, input logic [3:0] m);
    logic [15:0] ea_exp;
    @(negedge clk);
    mode = m;
    ea_exp = ref_ea(m);
    @(posedge clk);
    #1;
    check(req, ea, sfr, ea_exp, ref_sfr(m, ea_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    mode = 4'd1; imm = 16'h1234; hl = 16'hFFFF; de = 16'h5555; bc = 16'hAA55;
    pc = 16'h1000; bank = 2'd0; rn = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R13 reset", ea, sfr, 16'h0000, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    imm = 16'hBEEF;            run("R1 direct", 4'd0);
    imm = 16'h001F;            run("R2 short 1F", 4'd1);
    imm = 16'h0020;            run("R2 short 20", 4'd1);
    imm = 16'h00FF;            run("R2 short FF", 4'd1);
    imm = 16'h0000;            run("R2 short 00", 4'd1);
    imm = 16'h0000;            run("R3 sfr 00", 4'd2);
    imm = 16'h12AB;            run("R3 sfr AB", 4'd2);
    de = 16'hFF10;             run("R4 DE", 4'd3);
    hl = 16'h0123;             run("R4 HL", 4'd4);
    hl = 16'hFFFF; imm = 16'h0002; run("R5 based wrap", 4'd5);
    hl = 16'hFEF0; bc = 16'h1020;  run("R6 HL+B", 4'd6);
    run("R6 HL+C", 4'd7);
    bank = 2'd0; rn = 3'd0;    run("R7 bank0 r0", 4'd8);
    bank = 2'd3; rn = 3'd7;    run("R7 bank3 r7", 4'd8);
    bank = 2'd1; rn = 3'd2;    run("R7 bank1 r2", 4'd8);
    imm = 16'hFFFF;            run("R8 call 7FF", 4'd9);
    imm = 16'h0000;            run("R8 call 000", 4'd9);
    imm = 16'h001F;            run("R9 table 1F", 4'd10);
    imm = 16'h0000;            run("R9 table 00", 4'd10);
    pc = 16'h0000; imm = 16'h0080; run("R10 rel back", 4'd11);
    pc = 16'hFFFF; imm = 16'h007F; run("R10 rel wrap", 4'd11);
    pc = 16'hFF00; imm = 16'h0000; run("R11 branch in FFxx no flag", 4'd11);
    imm = 16'hFFFF;            run("R12 unused 15", 4'd15);
    run("R12 unused 12", 4'd12);

    for (int i = 0; i < 3000; i++) begin
      imm  = 16'($urandom);
      hl   = 16'($urandom);
      de   = 16'($urandom);
      bc   = 16'($urandom);
      pc   = 16'($urandom);
      bank = 2'($urandom);
      rn   = 3'($urandom);
      if (i % 4 == 0) hl = 16'hFF00 | 16'($urandom_range(0, 255));
      run("R11 random mix", 4'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule